// File: doc/BRIEF.md
# Byte-to-Word Packer with Residue Carry

This block sits in front of a checksum engine that only consumes whole 32-bit words. Software-level updates arrive as a sequence of commands. Each command announces a byte count and whether it closes the message. The command is followed by exactly that many bytes on a byte stream. The packer gathers the bytes into little-endian words and hands them on over a valid/ready word port. The 0 to 3 bytes that do not fill a word are held in a residue store and placed ahead of the next update's bytes.

When a closing command leaves a residue, the residue is zero-padded into one extra word. A per-update word count is issued before any word of that update leaves the block, so the engine side knows how many words to expect. An update with zero bytes that does not close the message is dropped. Backpressure on the word port stalls the byte stream, so no byte is lost.

Top module: `byte_word_packer`

## Requirements
- R1: Only whole 32-bit words are emitted. Bytes fill lanes little-endian: the earliest byte of a word lands in bits 7:0, and the next bytes go to 15:8, 23:16 and 31:24.
- R2: After an update, the (residue + new bytes) mod 4 leftover bytes stay in the residue store. On the next update they are emitted ahead of the new bytes, in their original order.
- R3: When residue plus new bytes totals fewer than 4 on a non-closing update, no word is emitted and all those bytes stay in the residue.
- R4: A closing command (cmd_final=1, with or without bytes) that leaves a nonzero residue emits one extra word. That word holds the residue bytes in the low lanes and zero in every unused upper lane.
- R5: A closing command that leaves an empty residue emits no extra word, and its reported count covers only the full words.
- R6: A command with cmd_nbytes=0 and cmd_final=0 is ignored. It produces no count pulse and no word, and the residue is unchanged.
- R7: For every command that is not ignored, cnt_valid pulses for one cycle in the cycle right after the command is accepted. cnt_words = floor((residue + cmd_nbytes)/4), plus 1 when the command closes the message and a residue remains. The pulse precedes every word of that update.
- R8: While out_valid is high and out_ready is low, out_valid and out_data hold and byte_ready is low. Every byte is eventually emitted exactly once.
- R9: After a closing command has been processed, the residue is empty, so the next update starts on a fresh word.
- R10: After reset, out_valid=0, cnt_valid=0, byte_ready=0, cmd_ready=1 and the residue is empty. cmd_ready is high only when no update is in progress and no word is pending.
- R11: byte_last must be high exactly on the final byte of an update. cmd_nbytes is an unsigned byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Update command offered |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_nbytes | input | LEN_W | Number of bytes that follow this command |
| cmd_final | input | 1 | Command closes the message (pad and flush residue) |
| byte_valid | input | 1 | Byte offered |
| byte_ready | output | 1 | Byte accepted this cycle when high with byte_valid |
| byte_data | input | 8 | Byte value |
| byte_last | input | 1 | Marks the final byte of the current update |
| out_valid | output | 1 | Packed word available |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Packed little-endian word |
| cnt_valid | output | 1 | One-cycle pulse carrying the update's word count |
| cnt_words | output | LEN_W | Words this update will emit |

## Verification
A wrong residue fill shows up on the very next emitted word. That word carries bytes shifted into the wrong lanes, repeated or missing, and the word count of the following update is off by one. The bench walks a vector table of update sizes, with and without stalls, against a byte-queue model. Each word is compared the cycle it is taken, and each count the cycle it pulses. A pad lane that was not cleared, or a residue that survives a closing command, corrupts the next word within one update. A broken hold under backpressure changes out_data between two consecutive stalled samples.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
  typedef enum logic [1:0] {
    WP_IDLE  = 2'd0,
    WP_BYTES = 2'd1,
    WP_PAD   = 2'd2
  } wp_state_e;
endpackage

// File: rtl/wpk_lane_acc.sv
module wpk_lane_acc #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int FILL_W = $clog2(LANES),
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_fire,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              pad_fire,
  output logic [FILL_W-1:0] fill,
  output logic              word_done,
  output logic [WORD_W-1:0] word_data
);
  localparam logic [FILL_W-1:0] TOP_LANE = FILL_W'(LANES - 1);

  logic [FILL_W-1:0] fill_q;
  logic [BYTE_W-1:0] lane_q [LANES];
  logic [LANES-1:0]  lane_sel;
  logic              wrap_byte;

  assign wrap_byte = byte_fire && (fill_q == TOP_LANE);
  assign word_done = wrap_byte || pad_fire;
  assign fill      = fill_q;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_sel[i] = byte_fire && (fill_q == FILL_W'(i));
      assign word_data[i*BYTE_W +: BYTE_W] = lane_sel[i] ? byte_data : lane_q[i];

      always_ff @(posedge clk) begin
        if (!rst_n)          lane_q[i] <= '0;
        else if (word_done)  lane_q[i] <= '0;
        else if (lane_sel[i]) lane_q[i] <= byte_data;
      end

      // R4: unused lanes stay zero so padding is clean
      a_r4_lane_zero_above_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_q[i] != '0) |-> (i < int'(fill_q)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)          fill_q <= '0;
    else if (word_done)  fill_q <= '0;
    else if (byte_fire)  fill_q <= fill_q + 1'b1;
  end

  a_r2_pad_only_with_residue: assert property (@(posedge clk) disable iff (!rst_n)
    pad_fire |-> (fill_q != '0));
endmodule

// File: rtl/wpk_out_slot.sv
module wpk_out_slot #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> slot_free);
endmodule

// File: rtl/wpk_ctrl.sv
module wpk_ctrl
  import wpk_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LEN_W = 12,
  localparam int FILL_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [LEN_W-1:0]  cmd_nbytes,
  input  logic              cmd_final,
  output logic              cmd_ready,
  input  logic              byte_valid,
  input  logic              byte_last,
  output logic              byte_ready,
  output logic              byte_fire,
  output logic              pad_fire,
  input  logic [FILL_W-1:0] fill,
  input  logic              slot_free,
  input  logic              slot_busy,
  output logic              cnt_valid,
  output logic [LEN_W-1:0]  cnt_words
);
  localparam logic [FILL_W-1:0] TOP_LANE = FILL_W'(LANES - 1);

  function automatic logic [LEN_W-1:0] words_for(input logic [FILL_W-1:0] f,
                                                 input logic [LEN_W-1:0]  n,
                                                 input logic              fin);
    logic [LEN_W:0] total;
    total = {1'b0, n} + (LEN_W+1)'(f);
    return LEN_W'(total / LANES) + LEN_W'(fin && ((total % LANES) != 0));
  endfunction

  function automatic logic tail_after_last(input logic [FILL_W-1:0] f, input logic fin);
    return fin && (f != TOP_LANE);
  endfunction

  wp_state_e        state_q;
  logic [LEN_W-1:0] rem_q;
  logic             fin_q;
  logic             cmd_fire;
  logic             cmd_ignored;
  logic             last_byte_fire;

  assign cmd_ready      = (state_q == WP_IDLE) && !slot_busy;
  assign cmd_fire       = cmd_valid && cmd_ready;
  assign cmd_ignored    = (cmd_nbytes == '0) && !cmd_final;
  assign byte_ready     = (state_q == WP_BYTES) && slot_free;
  assign byte_fire      = byte_valid && byte_ready;
  assign last_byte_fire = byte_fire && (rem_q == LEN_W'(1));
  assign pad_fire       = (state_q == WP_PAD) && slot_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= WP_IDLE;
      rem_q     <= '0;
      fin_q     <= 1'b0;
      cnt_valid <= 1'b0;
      cnt_words <= '0;
    end else begin
      cnt_valid <= 1'b0;
      unique case (state_q)
        WP_IDLE: if (cmd_fire) begin
          rem_q <= cmd_nbytes;
          fin_q <= cmd_final;
          if (!cmd_ignored) begin
            cnt_valid <= 1'b1;
            cnt_words <= words_for(fill, cmd_nbytes, cmd_final);
          end
          if (cmd_nbytes != '0)              state_q <= WP_BYTES;
          else if (cmd_final && fill != '0)  state_q <= WP_PAD;
        end
        WP_BYTES: if (byte_fire) begin
          rem_q <= rem_q - 1'b1;
          if (last_byte_fire)
            state_q <= tail_after_last(fill, fin_q) ? WP_PAD : WP_IDLE;
        end
        WP_PAD: if (pad_fire) state_q <= WP_IDLE;
        default: state_q <= WP_IDLE;
      endcase
    end
  end

  a_r11_last_marker: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fire |-> (byte_last == (rem_q == LEN_W'(1))));
  a_r6_ignored_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_ignored) |=> (state_q == WP_IDLE && !cnt_valid));
  a_r7_count_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_valid |-> $past(cmd_fire));
  a_r4_pad_has_residue: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WP_PAD) |-> (fill != '0));
endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer #(
  parameter int LANES = 4,
  parameter int LEN_W = 12,
  localparam int BYTE_W = 8,
  localparam int FILL_W = $clog2(LANES),
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [LEN_W-1:0]  cmd_nbytes,
  input  logic              cmd_final,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              cnt_valid,
  output logic [LEN_W-1:0]  cnt_words
);
  logic              byte_fire;
  logic              pad_fire;
  logic [FILL_W-1:0] fill;
  logic              word_done;
  logic [WORD_W-1:0] word_data;
  logic              slot_free;

  wpk_ctrl #(.LANES(LANES), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_nbytes(cmd_nbytes), .cmd_final(cmd_final),
    .cmd_ready(cmd_ready),
    .byte_valid(byte_valid), .byte_last(byte_last), .byte_ready(byte_ready),
    .byte_fire(byte_fire), .pad_fire(pad_fire),
    .fill(fill), .slot_free(slot_free), .slot_busy(out_valid),
    .cnt_valid(cnt_valid), .cnt_words(cnt_words)
  );

  wpk_lane_acc #(.LANES(LANES), .BYTE_W(BYTE_W)) acc_i (
    .clk(clk), .rst_n(rst_n),
    .byte_fire(byte_fire), .byte_data(byte_data), .pad_fire(pad_fire),
    .fill(fill), .word_done(word_done), .word_data(word_data)
  );

  wpk_out_slot #(.WORD_W(WORD_W)) slot_i (
    .clk(clk), .rst_n(rst_n),
    .load(word_done), .load_data(word_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .slot_free(slot_free)
  );

  a_r7_count_before_word: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_valid |-> !out_valid);
  a_r8_stall_blocks_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !byte_ready);
endmodule

// File: tb/byte_word_packer_tb.sv
module byte_word_packer_tb_top;
  localparam int LANES = 4;
  localparam int LEN_W = 12;
  localparam int NVEC  = 18;
  localparam int WDOG  = 60000;

  // entry: {final, stall, nbytes[7:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0,1'b0,8'd3}, {1'b0,1'b0,8'd1}, {1'b0,1'b0,8'd5}, {1'b0,1'b0,8'd0},
    {1'b1,1'b0,8'd2}, {1'b1,1'b0,8'd0}, {1'b0,1'b1,8'd4}, {1'b1,1'b1,8'd7},
    {1'b0,1'b0,8'd1}, {1'b1,1'b0,8'd0}, {1'b0,1'b1,8'd9}, {1'b0,1'b0,8'd0},
    {1'b1,1'b0,8'd3}, {1'b1,1'b1,8'd12},{1'b0,1'b0,8'd2}, {1'b0,1'b0,8'd1},
    {1'b1,1'b1,8'd1}, {1'b0,1'b1,8'd40}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0, cmd_final = 1'b0;
  logic [LEN_W-1:0] cmd_nbytes = '0;
  logic             byte_valid = 1'b0, byte_last = 1'b0;
  logic [7:0]       byte_data = '0;
  logic             out_ready = 1'b1;
  logic             cmd_ready, byte_ready, out_valid, cnt_valid;
  logic [31:0]      out_data;
  logic [LEN_W-1:0] cnt_words;

  byte_word_packer #(.LANES(LANES), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_nbytes(cmd_nbytes), .cmd_final(cmd_final),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data), .byte_last(byte_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .cnt_valid(cnt_valid), .cnt_words(cnt_words)
  );

  int          total_chk = 0;
  int          bad_chk = 0;
  int          cycles = 0;
  logic [7:0]  model_q[$];
  logic [31:0] exp_q[$];
  int          exp_cnt = 0;
  bit          exp_cnt_on = 0;
  int          upd_words = 0;
  bit          cnt_seen = 0;
  bit          stall_en = 0;
  logic [7:0]  bval = 8'h10;
  logic [15:0] lfsr = 16'hACE1;
  bit          hold_on = 0;
  logic [31:0] hold_data = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      bad_chk++;
      total_chk++;
      $display("FAIL watchdog got=%0d exp=%0d", cycles, WDOG);
      $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
    end
  end

  task automatic tick_begin();
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = stall_en ? lfsr[0] : 1'b1;
  endtask

  task automatic tick_end();
    logic [31:0] e;
    #1;
    if (hold_on) check(out_valid && (out_data == hold_data), "R8", out_data, hold_data);
    hold_on = 0;
    if (out_valid && !out_ready) begin
      hold_on = 1;
      hold_data = out_data;
      check(!byte_ready, "R8", 32'(byte_ready), 32'd0);
    end
    if (cnt_valid) begin
      check(exp_cnt_on, "R6", 32'd1, 32'd0);
      check(cnt_words == LEN_W'(exp_cnt), "R7", 32'(cnt_words), 32'(exp_cnt));
      check(upd_words == 0, "R7", 32'(upd_words), 32'd0);
      cnt_seen = 1;
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R1", out_data, 32'd0);
      else begin
        e = exp_q.pop_front();
        check(out_data == e, "R1", out_data, e);
      end
      upd_words++;
    end
  endtask

  task automatic finish_update(input string tag);
    bit done;
    repeat (2) begin tick_begin(); tick_end(); end
    done = cmd_ready;
    while (!done) begin tick_begin(); tick_end(); done = cmd_ready; end
    check(cnt_seen == exp_cnt_on, tag, 32'(cnt_seen), 32'(exp_cnt_on));
    check(upd_words == exp_cnt, tag, 32'(upd_words), 32'(exp_cnt));
    check(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic run_update(input int n, input bit f, input bit stall);
    string tag;
    int    res, words;
    bit    fired;
    logic [31:0] w;
    res = model_q.size();
    if (n == 0 && !f)               tag = "R6";
    else if (f && ((res + n) % 4) != 0) tag = "R4";
    else if (f)                     tag = "R5";
    else if (res + n < 4)           tag = "R3";
    else                            tag = "R2";
    for (int i = 0; i < n; i++) model_q.push_back(8'(bval + 8'(i)));
    words = 0;
    while (model_q.size() >= 4) begin
      w = {model_q[3], model_q[2], model_q[1], model_q[0]};
      repeat (4) void'(model_q.pop_front());
      exp_q.push_back(w);
      words++;
    end
    if (f && model_q.size() > 0) begin
      w = '0;
      for (int k = 0; k < model_q.size(); k++) w[k*8 +: 8] = model_q[k];
      exp_q.push_back(w);
      words++;
    end
    if (f) model_q.delete();
    exp_cnt = words;
    exp_cnt_on = !(n == 0 && !f);
    cnt_seen = 0;
    upd_words = 0;
    stall_en = stall;
    fired = 0;
    while (!fired) begin
      tick_begin();
      cmd_valid = 1'b1; cmd_nbytes = LEN_W'(n); cmd_final = f;
      tick_end();
      fired = cmd_ready;
    end
    for (int i = 0; i < n; i++) begin
      fired = 0;
      while (!fired) begin
        tick_begin();
        cmd_valid = 1'b0;
        byte_valid = 1'b1; byte_data = bval; byte_last = (i == n - 1);
        tick_end();
        fired = byte_ready;
      end
      bval = bval + 8'd1;
    end
    tick_begin();
    cmd_valid = 1'b0; byte_valid = 1'b0; byte_last = 1'b0;
    tick_end();
    finish_update(tag);
    stall_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: reset state
    check(!out_valid, "R10", 32'(out_valid), 32'd0);
    check(!cnt_valid, "R10", 32'(cnt_valid), 32'd0);
    check(cmd_ready, "R10", 32'(cmd_ready), 32'd1);
    check(!byte_ready, "R10", 32'(byte_ready), 32'd0);

    for (int v = 0; v < NVEC; v++)
      run_update(int'(VEC[v][7:0]), VEC[v][9], VEC[v][8]);

    // R9: closing update, then fresh word from the next update
    run_update(6, 1'b1, 1'b0);
    run_update(4, 1'b0, 1'b0);
    // R5: closing command exactly on a word boundary
    run_update(8, 1'b1, 1'b1);
    // R4: closing command padding three lanes
    run_update(1, 1'b1, 1'b0);

    // R10: reset discards a residue
    run_update(2, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    model_q.delete();
    exp_q.delete();
    hold_on = 0;
    @(negedge clk);
    rst_n = 1'b1;
    run_update(4, 1'b0, 1'b0);
    run_update(0, 1'b1, 1'b0);

    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end
endmodule